// File: doc/BRIEF.md
# Dual-Source Output Buffer and Interrupt Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary pointing-device channel, and the host-facing side of a peripheral controller. Each source raises a ready level while it holds a byte for the host. The block keeps a registered two-bit pending mask from those levels and derives, from that mask and the controller's mode byte, the buffer-full flags shown to software, the matching copies on the controller's output port, the two interrupt request levels, and the routing of a data-port read to one of the two sources.

The keyboard channel always wins: the auxiliary flag, the auxiliary interrupt and the auxiliary read route are only taken when the auxiliary source is the single source with data. The keyboard interrupt is further gated by an enable bit and a disable bit of the mode byte; the auxiliary interrupt only has an enable bit. All flag and interrupt outputs are registered and follow input changes one clock later. A read strobe is forwarded in the same cycle as a single pop pulse to the source the route currently selects.

Top module: `obf_irq_arbiter`

## Requirements
- R1: The pending mask holds bit 0 for keyboard data ready and bit 1 for auxiliary data ready; each bit takes its source's ready level at every clock edge, so outputs reflect a ready change one cycle later.
- R2: `stat_obf` and `port_obf` (output port bit 4) are 1 exactly when the pending mask is non-zero.
- R3: `stat_aux_obf` and `port_aux_obf` (output port bit 5) are 1 exactly when the pending mask equals 2'b10 (auxiliary only).
- R4: With the mask at 2'b10, `irq_aux` equals mode bit 1 and `irq_kbd` is 0; mode bit 4 has no effect on `irq_aux`.
- R5: With mask 2'b01 or 2'b11, `irq_kbd` is 1 exactly when mode bit 0 is 1 and mode bit 4 is 0, and `irq_aux` is 0.
- R6: With the mask at 2'b00 both interrupt levels are 0, whatever the mode byte.
- R7: `rd_sel_aux` is 1 only when the mask equals 2'b10; in every other case reads route to the keyboard source.
- R8: While `rd_stb` is 1, exactly the pop output of the selected source is 1 in the same cycle; with `rd_stb` at 0 both pops are 0.
- R9: A mode byte change with ready levels held steady changes the interrupt levels one clock later and not before.
- R10: While `rst_n` is 0 every output except the pops is 0, and the pending mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_ready | input | 1 | Keyboard source holds a byte |
| aux_ready | input | 1 | Auxiliary source holds a byte |
| mode | input | 8 | Controller mode byte (bit 0 kbd irq enable, bit 1 aux irq enable, bit 4 kbd disable) |
| rd_stb | input | 1 | Host data-port read strobe |
| stat_obf | output | 1 | Status: output buffer full |
| stat_aux_obf | output | 1 | Status: buffer holds auxiliary data |
| port_obf | output | 1 | Output port bit 4 copy of buffer full |
| port_aux_obf | output | 1 | Output port bit 5 copy of auxiliary full |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| rd_sel_aux | output | 1 | Data read routes to auxiliary source |
| kbd_pop | output | 1 | Pop pulse to keyboard source |
| aux_pop | output | 1 | Pop pulse to auxiliary source |

## Verification
The bench targets the both-ready case, where a design that treated the mask as "aux bit set" instead of "aux only" would raise the auxiliary flag, the auxiliary interrupt and the auxiliary read route together with the keyboard ones. It checks that the keyboard disable bit silences only the keyboard interrupt, so a design that applied it to both channels would lose auxiliary interrupts. It probes the cycle just after a mode change to catch a combinational interrupt path, and it strobes reads in each mask state to catch a pop sent to both sources or to the wrong one.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NSRC    = 2;
    localparam int SRC_KBD = 0;
    localparam int SRC_AUX = 1;

    typedef enum logic [NSRC-1:0] {
        PEND_NONE = 2'b00,
        PEND_KBD  = 2'b01,
        PEND_AUX  = 2'b10,
        PEND_BOTH = 2'b11
    } pend_e;

    typedef struct packed {
        logic aux;
        logic kbd;
    } irq_t;

endpackage

// File: rtl/arb_pend_track.sv
module arb_pend_track
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  ready,
    output logic [NSRC-1:0]  pend_q
);

    logic [NSRC-1:0] pend_d;

    always_comb begin
        pend_d = ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_follow
        p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) or 1'b1 |=> (pend_q[g] == $past(ready[g])))
            else $error("pending bit does not follow its ready level");
    end

endmodule

// File: rtl/arb_irq_gen.sv
module arb_irq_gen
    import arb_pkg::*;
#(
    parameter int MODE_W   = 8,
    parameter int KEN_BIT  = 0,
    parameter int AEN_BIT  = 1,
    parameter int KDIS_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pend_nx,
    input  logic [MODE_W-1:0] mode,
    output logic              irq_kbd,
    output logic              irq_aux
);

    irq_t irq_d, irq_q;
    logic kbd_allowed;

    always_comb begin
        kbd_allowed = mode[KEN_BIT] & ~mode[KDIS_BIT];
        irq_d       = '0;
        unique case (pend_e'(pend_nx))
            PEND_NONE: irq_d = '0;
            PEND_AUX:  irq_d.aux = mode[AEN_BIT];
            PEND_KBD,
            PEND_BOTH: irq_d.kbd = kbd_allowed;
            default:   irq_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_kbd = irq_q.kbd;
    assign irq_aux = irq_q.aux;

    p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_q.kbd, irq_q.aux}))
        else $error("both interrupt levels high");

    p_aux_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_nx == PEND_AUX) |=> (!irq_q.kbd && (irq_q.aux == $past(mode[AEN_BIT]))))
        else $error("aux-only interrupt wrong");

    p_kbd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_nx[SRC_KBD] && mode[KDIS_BIT]) |=> !irq_q.kbd)
        else $error("keyboard irq raised while disabled");

    p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_nx == PEND_NONE) |=> (!irq_q.kbd && !irq_q.aux))
        else $error("interrupt with nothing pending");

endmodule

// File: rtl/arb_rd_route.sv
module arb_rd_route
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend_q,
    input  logic             rd_stb,
    output logic             obf,
    output logic             aux_obf,
    output logic             sel_aux,
    output logic             kbd_pop,
    output logic             aux_pop
);

    always_comb begin
        obf     = |pend_q;
        aux_obf = (pend_e'(pend_q) == PEND_AUX);
        sel_aux = aux_obf;
        kbd_pop = rd_stb & ~sel_aux;
        aux_pop = rd_stb &  sel_aux;
    end

    p_pop_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $onehot({kbd_pop, aux_pop}))
        else $error("read strobe not routed to exactly one source");

    p_pop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> !(kbd_pop || aux_pop))
        else $error("pop without read strobe");

    p_aux_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        aux_obf |-> (obf && !pend_q[SRC_KBD]))
        else $error("aux flag while keyboard pending");

    p_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[SRC_KBD] |-> !sel_aux)
        else $error("read routed to aux while keyboard pending");

endmodule

// File: rtl/obf_irq_arbiter.sv
module obf_irq_arbiter
    import arb_pkg::*;
#(
    parameter int MODE_W   = 8,
    parameter int KEN_BIT  = 0,
    parameter int AEN_BIT  = 1,
    parameter int KDIS_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_ready,
    input  logic              aux_ready,
    input  logic [MODE_W-1:0] mode,
    input  logic              rd_stb,
    output logic              stat_obf,
    output logic              stat_aux_obf,
    output logic              port_obf,
    output logic              port_aux_obf,
    output logic              irq_kbd,
    output logic              irq_aux,
    output logic              rd_sel_aux,
    output logic              kbd_pop,
    output logic              aux_pop
);

    logic [NSRC-1:0] ready_w;
    logic [NSRC-1:0] pend_q;
    logic            obf_w;
    logic            aux_obf_w;

    assign ready_w[SRC_KBD] = kbd_ready;
    assign ready_w[SRC_AUX] = aux_ready;

    arb_pend_track u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready  (ready_w),
        .pend_q (pend_q)
    );

    arb_irq_gen #(
        .MODE_W   (MODE_W),
        .KEN_BIT  (KEN_BIT),
        .AEN_BIT  (AEN_BIT),
        .KDIS_BIT (KDIS_BIT)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_nx (ready_w),
        .mode    (mode),
        .irq_kbd (irq_kbd),
        .irq_aux (irq_aux)
    );

    arb_rd_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_q  (pend_q),
        .rd_stb  (rd_stb),
        .obf     (obf_w),
        .aux_obf (aux_obf_w),
        .sel_aux (rd_sel_aux),
        .kbd_pop (kbd_pop),
        .aux_pop (aux_pop)
    );

    assign stat_obf     = obf_w;
    assign port_obf     = obf_w;
    assign stat_aux_obf = aux_obf_w;
    assign port_aux_obf = aux_obf_w;

    p_obf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_ready || aux_ready) |=> stat_obf)
        else $error("buffer-full flag missing");

    p_irq_needs_obf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_kbd || irq_aux) |-> stat_obf)
        else $error("interrupt with empty buffer");

endmodule

// File: tb/obf_irq_arbiter_tb.sv
module obf_irq_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // {kbd, aux, mode[7:0], obf, aux_obf, irq_kbd, irq_aux, sel_aux}
    localparam logic [14:0] VECS [NVEC] = '{
        {2'b00, 8'h03, 5'b00000},
        {2'b10, 8'h03, 5'b10100},
        {2'b01, 8'h03, 5'b11011},
        {2'b11, 8'h03, 5'b10100},
        {2'b10, 8'h13, 5'b10000},
        {2'b01, 8'h13, 5'b11011},
        {2'b01, 8'h01, 5'b11001},
        {2'b10, 8'h02, 5'b10000},
        {2'b11, 8'h02, 5'b10000},
        {2'b11, 8'h11, 5'b10000},
        {2'b00, 8'hFF, 5'b00000},
        {2'b01, 8'hFF, 5'b11011},
        {2'b10, 8'hEF, 5'b10100}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_ready = 1'b0;
    logic       aux_ready = 1'b0;
    logic [7:0] mode = 8'h03;
    logic       rd_stb = 1'b0;
    logic stat_obf, stat_aux_obf, port_obf, port_aux_obf;
    logic irq_kbd, irq_aux, rd_sel_aux, kbd_pop, aux_pop;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    obf_irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .kbd_ready(kbd_ready), .aux_ready(aux_ready),
        .mode(mode), .rd_stb(rd_stb), .stat_obf(stat_obf), .stat_aux_obf(stat_aux_obf),
        .port_obf(port_obf), .port_aux_obf(port_aux_obf), .irq_kbd(irq_kbd),
        .irq_aux(irq_aux), .rd_sel_aux(rd_sel_aux), .kbd_pop(kbd_pop), .aux_pop(aux_pop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] observed();
        return {stat_obf, stat_aux_obf, irq_kbd, irq_aux, rd_sel_aux};
    endfunction

    task automatic apply(input logic k, input logic a, input logic [7:0] m);
        @(negedge clk);
        kbd_ready = k;
        aux_ready = a;
        mode = m;
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state with sources ready
        kbd_ready = 1'b1;
        aux_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {27'd0, observed()}, 32'd0);
        check("R10 reset port bits", {30'd0, port_obf, port_aux_obf}, 32'd0);
        kbd_ready = 1'b0;
        aux_ready = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1..R7
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][14], VECS[i][13], VECS[i][12:5]);
            check("R1-table R2 R3 R4 R5 R6 R7 vector", {27'd0, observed()}, {27'd0, VECS[i][4:0]});
            check("R2 R3 port mirror", {30'd0, port_obf, port_aux_obf},
                  {30'd0, VECS[i][4], VECS[i][3]});
        end

        // R1: one-cycle latency of the pending mask
        apply(1'b0, 1'b0, 8'h03);
        @(negedge clk);
        aux_ready = 1'b1;
        #1;
        check("R1 before edge still empty", {31'd0, stat_obf}, 32'd0);
        @(negedge clk);
        check("R1 after edge aux pending", {30'd0, stat_aux_obf, rd_sel_aux}, 32'd3);

        // R8: pop routing
        rd_stb = 1'b1;
        #1;
        check("R8 aux-only pops aux", {30'd0, kbd_pop, aux_pop}, 32'd1);
        @(negedge clk);
        rd_stb = 1'b0;
        kbd_ready = 1'b1;
        @(negedge clk);
        check("R8 no pop without strobe", {30'd0, kbd_pop, aux_pop}, 32'd0);
        rd_stb = 1'b1;
        #1;
        check("R8 both pending pops kbd", {30'd0, kbd_pop, aux_pop}, 32'd2);
        @(negedge clk);
        rd_stb = 1'b0;

        // R9: mode change latency, keyboard pending
        aux_ready = 1'b0;
        @(negedge clk);
        check("R9 kbd irq enabled", {31'd0, irq_kbd}, 32'd1);
        mode = 8'h13;
        #1;
        check("R9 irq unchanged before edge", {31'd0, irq_kbd}, 32'd1);
        @(negedge clk);
        check("R9 irq low after disable", {31'd0, irq_kbd}, 32'd0);
        mode = 8'h03;
        @(negedge clk);
        check("R9 irq back after enable", {31'd0, irq_kbd}, 32'd1);

        // R6: empty mask with every mode bit set
        apply(1'b0, 1'b0, 8'hFF);
        check("R6 empty no irq", {30'd0, irq_kbd, irq_aux}, 32'd0);

        // R10: reset mid-run clears state
        apply(1'b0, 1'b1, 8'h03);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset", {27'd0, observed()}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R4 after reset release", {27'd0, observed()}, 32'b11011);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule